// File: doc/BRIEF.md
# Interruptible Integer Divider Peripheral

This block is a 32-bit integer divider attached to a simple register bus. Software writes a dividend and then a divisor. Two register addresses accept unsigned operands and two accept signed operands. The write to a divisor register starts the operation. A fixed number of cycles later the quotient and remainder registers hold the result, and a status register reports completion.

The unit is built to be shared by code that can be pre-empted. A status flag records whether any operand or result register has been written since the quotient was last read. An interrupt or task-switch routine reads that flag and skips the save when nothing is pending. To save, it waits until the unit is idle and then reads the registers in a fixed order: remainder first, then quotient. The result registers accept writes, so a saved state can be put back. Such a write cancels any division in progress.

Top module: `mmdiv`

## Requirements
- R1: Offsets 0x60 (unsigned) and 0x68 (signed) both access one dividend register. Offsets 0x64 (unsigned) and 0x6C (signed) both access one divisor register. Each operand register reads back the value last written at either of its offsets.
- R2: A write to either divisor offset starts a division on the most recently written dividend. Status bit 0 (ready, at offset 0x78) is 0 in the 8 cycles after the write edge and is 1 again after the 8th rising edge that follows the write edge. The latency is the same for every operand pair.
- R3: Unsigned operations give quotient = dividend / divisor at 0x70 and remainder = dividend mod divisor at 0x74.
- R4: Signed operations truncate toward zero, and the remainder carries the sign of the dividend. 0x80000000 / -1 gives quotient 0x80000000 and remainder 0.
- R5: For a zero divisor, the unsigned quotient is 0xFFFFFFFF. The signed quotient is -1 for a non-negative dividend and +1 for a negative one. In both cases the remainder equals the dividend and the latency stays 8 cycles.
- R6: Status bit 1 (dirty) becomes 1 after any write to an operand register (0x60, 0x64, 0x68, 0x6C) or a result register (0x70, 0x74).
- R7: A read of the quotient register (0x70) clears dirty. A read of the remainder register does not change it.
- R8: A write to the quotient or remainder register cancels any division in progress and sets ready on the next cycle. The written value is held and is not later overwritten by the cancelled operation.
- R9: The status register is read-only. A write to 0x78 changes neither ready nor dirty.
- R10: After reset, every data register reads 0, ready is 1 and dirty is 0.
- R11: A divisor write during a running division restarts it with the new operands. The 8-cycle latency counts from the latest divisor write.
- R12: Read data is 0 when the read enable is low or the address maps to no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; read data is combinational, and a quotient read clears dirty at the edge |
| rd_data | output | 32 | Read data |

## Verification
The ready flag is due low right after the divisor write edge and high after the 8th later edge. The bench therefore samples the status register at each of the eight falling edges that follow the write, and again at the ninth. Results are read only after that ninth falling edge. Register read data is combinational, so each read is sampled 1 ns after a falling edge.

Effects caused by an edge are checked at the falling edge that follows it. These are:
- the ready flag after a result-register write;
- the dirty flag after a write;
- the clearing of dirty by a quotient read.

For restart and cancel, the bench computes from the last divisor write when ready is due. It confirms that written result values survive past the point where the cancelled operation would have ended.

// File: rtl/mmdiv_pkg.sv
// Shared definitions for the divider peripheral: register offsets,
// status bit positions and the address decoder.
package mmdiv_pkg;

    localparam logic [7:0] OFS_UDVD = 8'h60;
    localparam logic [7:0] OFS_UDVS = 8'h64;
    localparam logic [7:0] OFS_SDVD = 8'h68;
    localparam logic [7:0] OFS_SDVS = 8'h6C;
    localparam logic [7:0] OFS_QUOT = 8'h70;
    localparam logic [7:0] OFS_REM  = 8'h74;
    localparam logic [7:0] OFS_STAT = 8'h78;

    localparam int STAT_READY_BIT = 0;
    localparam int STAT_DIRTY_BIT = 1;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_UDVD, SEL_UDVS, SEL_SDVD,
        SEL_SDVS, SEL_QUOT, SEL_REM,  SEL_STAT
    } reg_sel_e;

    // Map a byte offset onto a register selector.
    function automatic reg_sel_e decode_ofs(input logic [7:0] a);
        case (a)
            OFS_UDVD: return SEL_UDVD;
            OFS_UDVS: return SEL_UDVS;
            OFS_SDVD: return SEL_SDVD;
            OFS_SDVS: return SEL_SDVS;
            OFS_QUOT: return SEL_QUOT;
            OFS_REM:  return SEL_REM;
            OFS_STAT: return SEL_STAT;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/div_step.sv
// One radix-2 restoring step.
// The next dividend bit is shifted into the partial remainder, and the
// divisor is subtracted when it fits. One quotient bit enters at the
// bottom of the shift register.
// Assumes the partial remainder is below the divisor, or that the
// divisor is zero. Either way the result fits in W bits.
module div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] shf_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] shf_o
);
    logic [W:0] cat;
    logic [W:0] diff;

    // Trial subtraction; the borrow bit decides keep or restore.
    always_comb begin
        cat  = {rem_i, shf_i[W-1]};
        diff = cat - {1'b0, dvs_i};
        if (diff[W]) begin
            rem_o = cat[W-1:0];
            shf_o = {shf_i[W-2:0], 1'b0};
        end else begin
            rem_o = diff[W-1:0];
            shf_o = {shf_i[W-2:0], 1'b1};
        end
    end
endmodule

// File: rtl/div_iter_core.sv
// Iterative divider core.
// Works on operand magnitudes and retires RADIX_BITS quotient bits per
// cycle, using that many chained radix-2 restoring steps. The signs of
// the results are applied on the way out.
// Assumes W is a multiple of RADIX_BITS.
// start_i loads new operands. abort_i stops a running operation.
// fin_o is high in the final iteration cycle, together with the
// finished quotient and remainder.
module div_iter_core #(
    parameter int W          = 32,
    parameter int RADIX_BITS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         signed_i,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dvs_i,
    input  logic         abort_i,
    output logic         busy_o,
    output logic         fin_o,
    output logic [W-1:0] quot_o,
    output logic [W-1:0] rem_o
);
    localparam int ITER = W / RADIX_BITS;
    localparam int CW   = (ITER > 1) ? $clog2(ITER) : 1;

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  rem_q, shf_q, dvs_q;
    logic          negq_q, negr_q;

    logic          dvd_neg, dvs_neg;
    logic [W-1:0]  dvd_mag, dvs_mag;

    logic [W-1:0]  rem_c [RADIX_BITS+1];
    logic [W-1:0]  shf_c [RADIX_BITS+1];

    // Magnitudes and signs of the incoming operands.
    always_comb begin
        dvd_neg = signed_i & dvd_i[W-1];
        dvs_neg = signed_i & dvs_i[W-1];
        dvd_mag = dvd_neg ? (~dvd_i + 1'b1) : dvd_i;
        dvs_mag = dvs_neg ? (~dvs_i + 1'b1) : dvs_i;
    end

    assign rem_c[0] = rem_q;
    assign shf_c[0] = shf_q;

    // One radix-2 step per quotient bit retired in a cycle.
    for (genvar g = 0; g < RADIX_BITS; g++) begin : g_step
        div_step #(.W(W)) u_step (
            .rem_i (rem_c[g]),
            .shf_i (shf_c[g]),
            .dvs_i (dvs_q),
            .rem_o (rem_c[g+1]),
            .shf_o (shf_c[g+1])
        );
    end

    // Iteration state: load, cancel, or advance one radix step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            rem_q  <= '0;
            shf_q  <= '0;
            dvs_q  <= '0;
            negq_q <= 1'b0;
            negr_q <= 1'b0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            rem_q  <= '0;
            shf_q  <= dvd_mag;
            dvs_q  <= dvs_mag;
            negq_q <= dvd_neg ^ dvs_neg;
            negr_q <= dvd_neg;
        end else if (abort_i) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            rem_q <= rem_c[RADIX_BITS];
            shf_q <= shf_c[RADIX_BITS];
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(ITER - 1)) busy_q <= 1'b0;
        end
    end

    // Final-cycle strobe and sign-corrected outputs.
    always_comb begin
        fin_o  = busy_q && (cnt_q == CW'(ITER - 1)) && !start_i && !abort_i;
        quot_o = negq_q ? (~shf_c[RADIX_BITS] + 1'b1) : shf_c[RADIX_BITS];
        rem_o  = negr_q ? (~rem_c[RADIX_BITS] + 1'b1) : rem_c[RADIX_BITS];
    end

    assign busy_o = busy_q;
endmodule

// File: rtl/mmdiv.sv
// Register-mapped integer divider with a state-save interface.
// Holds the operand, result and status registers and decodes the bus.
// Starts the core on a divisor write. Result-register writes restore
// saved state and cancel work in flight.
// Assumes at most one bus access per cycle.
// Read data is combinational from the registers.
module mmdiv #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8,
    parameter int RADIX_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    import mmdiv_pkg::*;

    reg_sel_e          sel;
    logic [DATA_W-1:0] dvd_q, dvs_q, quot_q, rem_q;
    logic              dirty_q;
    logic              ready_w;
    logic              wr_dvd, wr_dvs, wr_sgn, wr_quot, wr_rem, rd_quot;
    logic              core_busy, core_fin;
    logic [DATA_W-1:0] core_quot, core_rem;

    // Decode the access into per-register strobes.
    always_comb begin
        sel     = decode_ofs(addr[7:0]);
        wr_dvd  = wr_en && (sel == SEL_UDVD || sel == SEL_SDVD);
        wr_dvs  = wr_en && (sel == SEL_UDVS || sel == SEL_SDVS);
        wr_sgn  = (sel == SEL_SDVS);
        wr_quot = wr_en && (sel == SEL_QUOT);
        wr_rem  = wr_en && (sel == SEL_REM);
        rd_quot = rd_en && (sel == SEL_QUOT);
    end

    div_iter_core #(.W(DATA_W), .RADIX_BITS(RADIX_BITS)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (wr_dvs),
        .signed_i (wr_sgn),
        .dvd_i    (dvd_q),
        .dvs_i    (wr_data),
        .abort_i  (wr_quot | wr_rem),
        .busy_o   (core_busy),
        .fin_o    (core_fin),
        .quot_o   (core_quot),
        .rem_o    (core_rem)
    );

    assign ready_w = !core_busy;

    // Operand registers keep the last written values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q <= '0;
            dvs_q <= '0;
        end else begin
            if (wr_dvd) dvd_q <= wr_data;
            if (wr_dvs) dvs_q <= wr_data;
        end
    end

    // Result registers: a bus restore has priority over completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quot_q <= '0;
            rem_q  <= '0;
        end else begin
            if (wr_quot)       quot_q <= wr_data;
            else if (core_fin) quot_q <= core_quot;
            if (wr_rem)        rem_q  <= wr_data;
            else if (core_fin) rem_q  <= core_rem;
        end
    end

    // Dirty flag: set by state writes, cleared by a quotient read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     dirty_q <= 1'b0;
        else if (wr_dvd || wr_dvs || wr_quot || wr_rem) dirty_q <= 1'b1;
        else if (rd_quot)                               dirty_q <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (sel)
                SEL_UDVD, SEL_SDVD: rd_data = dvd_q;
                SEL_UDVS, SEL_SDVS: rd_data = dvs_q;
                SEL_QUOT:           rd_data = quot_q;
                SEL_REM:            rd_data = rem_q;
                SEL_STAT: begin
                    rd_data[STAT_READY_BIT] = ready_w;
                    rd_data[STAT_DIRTY_BIT] = dirty_q;
                end
                default:            rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/mmdiv_chk.sv
// Protocol checker for the divider peripheral.
// Decodes the bus independently and watches the ready flag, the dirty
// flag and the result registers. A local counter measures the latency
// window.
module mmdiv_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic              ready_w,
    input logic              dirty_q,
    input logic [DATA_W-1:0] quot_q,
    input logic [DATA_W-1:0] rem_q
);
    logic       is_dvs, is_state, is_res, is_quot, is_stat;
    logic [3:0] lat_cnt;

    always_comb begin
        is_dvs   = (addr[7:0] == 8'h64) || (addr[7:0] == 8'h6C);
        is_res   = (addr[7:0] == 8'h70) || (addr[7:0] == 8'h74);
        is_state = is_dvs || is_res || (addr[7:0] == 8'h60) || (addr[7:0] == 8'h68);
        is_quot  = (addr[7:0] == 8'h70);
        is_stat  = (addr[7:0] == 8'h78);
    end

    // Cycles elapsed since the latest divisor write while not ready.
    always_ff @(posedge clk) begin
        if (!rst_n)                          lat_cnt <= '0;
        else if (wr_en && is_dvs)            lat_cnt <= '0;
        else if (!ready_w && lat_cnt != 4'hF) lat_cnt <= lat_cnt + 1'b1;
    end

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_dvs) |=> !ready_w);
    p_hold_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_w && lat_cnt < 4'd7 && !wr_en) |=> !ready_w);
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_w && lat_cnt == 4'd7 && !wr_en) |=> ready_w);
    p_dirty_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_state) |=> dirty_q);
    p_dirty_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && is_quot && !wr_en) |=> !dirty_q);
    p_abort_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_res) |=> ready_w);
    p_abort_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_quot) |=> (quot_q == $past(wr_data)));
    p_stat_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_stat && !rd_en) |=> $stable(dirty_q));
    p_result_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_w && !wr_en) |=> ($stable(quot_q) && $stable(rem_q)));
endmodule

bind mmdiv mmdiv_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .ready_w (ready_w),
    .dirty_q (dirty_q),
    .quot_q  (quot_q),
    .rem_q   (rem_q)
);

// File: tb/tb_mmdiv.sv
`timescale 1ns/1ps
module tb_mmdiv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #2.5 clk = ~clk;

    mmdiv dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Combinational read at the next falling edge, no clock edge consumed.
    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        rd_en = 1'b0;
    endtask

    // Read held through one rising edge (quotient read clears dirty).
    task automatic rd_edge(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    function automatic logic [31:0] next_rand();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    task automatic ref_div(input bit sgn, input logic [31:0] a, input logic [31:0] b,
                           output logic [31:0] q, output logic [31:0] r);
        if (b == 0) begin
            q = (sgn && a[31]) ? 32'h1 : 32'hFFFF_FFFF;
            r = a;
        end else if (!sgn) begin
            q = a / b; r = a % b;
        end else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
            q = 32'h8000_0000; r = 0;
        end else begin
            q = $signed(a) / $signed(b);
            r = $signed(a) % $signed(b);
        end
    endtask

    // After a divisor write: ready low at 8 falling edges, then high.
    task automatic check_latency(input string req);
        logic [31:0] s;
        int bad = 0;
        for (int i = 0; i < 8; i++) begin
            peek(8'h78, s);
            if (s[0] !== 1'b0) bad++;
        end
        peek(8'h78, s);
        if (s[0] !== 1'b1) bad++;
        check(req, bad, 0);
    endtask

    task automatic run_div(input bit sgn, input logic [31:0] a, input logic [31:0] b, input string req);
        logic [31:0] q, r, eq, er;
        bus_wr(sgn ? 8'h68 : 8'h60, a);
        bus_wr(sgn ? 8'h6C : 8'h64, b);
        repeat (8) @(negedge clk);
        rd_edge(8'h74, r);
        rd_edge(8'h70, q);
        ref_div(sgn, a, b, eq, er);
        check({req, " quotient"}, q, eq);
        check({req, " remainder"}, r, er);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        peek(8'h78, d); check("R10 status", d, 32'h1);
        peek(8'h60, d); check("R10 dividend", d, 0);
        peek(8'h64, d); check("R10 divisor", d, 0);
        peek(8'h70, d); check("R10 quotient", d, 0);
        peek(8'h74, d); check("R10 remainder", d, 0);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        bus_wr(8'h60, 32'hDEAD_0001);
        peek(8'h68, d); check("R1 dividend alias", d, 32'hDEAD_0001);
        bus_wr(8'h6C, 32'h0000_0077);
        peek(8'h64, d); check("R1 divisor alias", d, 32'h0000_0077);
        repeat (9) @(negedge clk);
    endtask

    task automatic t_latency();
        bus_wr(8'h60, 32'd1000);
        bus_wr(8'h64, 32'd7);
        check_latency("R2 latency");
        bus_wr(8'h64, 32'd1);
        check_latency("R2 latency divisor one");
    endtask

    task automatic t_unsigned();
        run_div(0, 32'd100, 32'd7, "R3 100/7");
        run_div(0, 32'hFFFF_FFFF, 32'd1, "R3 max/1");
        run_div(0, 32'd5, 32'd9, "R3 small/large");
        run_div(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 max/max");
        for (int i = 0; i < 30; i++) begin
            logic [31:0] a, b;
            a = next_rand();
            b = next_rand() >> (i % 32);
            if (b == 0) b = 32'd3;
            run_div(0, a, b, "R3 random");
        end
    endtask

    task automatic t_signed();
        run_div(1, -32'sd7, 32'sd2, "R4 -7/2");
        run_div(1, 32'sd7, -32'sd2, "R4 7/-2");
        run_div(1, -32'sd7, -32'sd2, "R4 -7/-2");
        run_div(1, 32'h8000_0000, 32'hFFFF_FFFF, "R4 min/-1");
        run_div(1, 32'h8000_0000, 32'd1, "R4 min/1");
        for (int i = 0; i < 30; i++) begin
            logic [31:0] a, b;
            a = next_rand();
            b = $unsigned($signed(next_rand()) >>> (i % 31));
            if (b == 0) b = 32'hFFFF_FFFD;
            run_div(1, a, b, "R4 random");
        end
    endtask

    task automatic t_divzero();
        run_div(0, 32'h1234_5678, 32'd0, "R5 unsigned zero");
        run_div(1, 32'd42, 32'd0, "R5 signed positive zero");
        run_div(1, -32'sd42, 32'd0, "R5 signed negative zero");
        bus_wr(8'h60, 32'd9);
        bus_wr(8'h64, 32'd0);
        check_latency("R5 latency with zero divisor");
    endtask

    task automatic t_dirty();
        logic [31:0] d;
        rd_edge(8'h70, d);
        peek(8'h78, d); check("R7 dirty cleared by quotient read", d[1], 0);
        bus_wr(8'h74, 32'h55);
        peek(8'h78, d); check("R6 dirty after remainder write", d[1], 1);
        rd_edge(8'h74, d);
        peek(8'h78, d); check("R7 remainder read keeps dirty", d[1], 1);
        rd_edge(8'h70, d);
        peek(8'h78, d); check("R7 dirty cleared again", d[1], 0);
        bus_wr(8'h68, 32'h3);
        peek(8'h78, d); check("R6 dirty after dividend write", d[1], 1);
        rd_edge(8'h70, d);
    endtask

    task automatic t_abort();
        logic [31:0] d, rem_before;
        bus_wr(8'h74, 32'hCAFE_F00D);
        rem_before = 32'hCAFE_F00D;
        bus_wr(8'h60, 32'd999_999);
        bus_wr(8'h64, 32'd3);
        repeat (2) @(negedge clk);
        bus_wr(8'h70, 32'h0000_1234);
        peek(8'h78, d); check("R8 ready after quotient restore", d[0], 1);
        repeat (12) @(negedge clk);
        peek(8'h70, d); check("R8 quotient held", d, 32'h0000_1234);
        peek(8'h74, d); check("R8 remainder untouched", d, rem_before);
        bus_wr(8'h64, 32'd5);
        repeat (3) @(negedge clk);
        bus_wr(8'h74, 32'h0BAD_BEEF);
        peek(8'h78, d); check("R8 ready after remainder restore", d[0], 1);
        repeat (12) @(negedge clk);
        peek(8'h74, d); check("R8 remainder held", d, 32'h0BAD_BEEF);
    endtask

    task automatic t_stat_ignored();
        logic [31:0] d;
        rd_edge(8'h70, d);
        bus_wr(8'h78, 32'hFFFF_FFFF);
        peek(8'h78, d); check("R9 status write ignored", d, 32'h1);
    endtask

    task automatic t_restart();
        logic [31:0] q, r;
        bus_wr(8'h60, 32'd1000);
        bus_wr(8'h64, 32'd3);
        repeat (3) @(negedge clk);
        bus_wr(8'h64, 32'd7);
        check_latency("R11 latency from last divisor write");
        rd_edge(8'h74, r);
        rd_edge(8'h70, q);
        check("R11 restarted quotient", q, 32'd142);
        check("R11 restarted remainder", r, 32'd6);
    endtask

    task automatic t_rdgate();
        logic [31:0] d;
        @(negedge clk);
        addr = 8'h70; rd_en = 1'b0;
        #1 check("R12 read data zero without enable", rd_data, 0);
        peek(8'h7C, d); check("R12 unmapped offset", d, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_readback();
        t_latency();
        t_unsigned();
        t_signed();
        t_divzero();
        t_dirty();
        t_abort();
        t_stat_ignored();
        t_restart();
        t_rdgate();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule